// File: doc/BRIEF.md
# Keyed Watchdog Timer with Configuration Lock

This block is a watchdog timer for a small system-on-chip, controlled over a simple 32-bit register bus. A free-running counter advances while the watchdog is enabled. If software fails to service it before the counter reaches a programmed limit, the block issues a single-cycle reset request. Servicing is done by writing an ordered pair of key words to the command register. A stray or misordered key is treated as a fault.

The configuration registers (control, timeout limit and window) are protected. After reset they may be written directly exactly once, provided the update-permission bit is still clear. From then on they are writable only inside a short unlocked interval. That interval is opened by a second key pair, and only when the update-permission bit is set. A new control word takes effect a fixed number of cycles after it is written, and a status bit then reports that the reconfiguration is complete.

An optional refresh window makes early servicing illegal as well as late servicing. This guards against software that refreshes from a tight loop.

Top module: `wdt_seqlock`

## Requirements
- R1: After reset, offset 0x0 (control) reads 0x80, offset 0x8 (timeout limit) reads 0x400 and offset 0xC (window) reads 0, and rst_req is low. In the control word, bit 7 is enable, bit 5 is update-permission, bit 10 is reconfiguration-complete and bit 11 is unlocked. A read on bus_rd returns data on bus_rdata one cycle later. Offset 0x4 reads the current counter.
- R2: While update-permission is clear and no control write has been accepted since reset, writes to offsets 0x0, 0x8 and 0xC are accepted. Once a control write has been accepted, the timeout and window registers ignore writes unless the block is unlocked.
- R3: An accepted control write updates enable and update-permission exactly 2 cycles later and sets bit 10 at that same point. Reads in between return the previous control value.
- R4: Writing 0xC520 and then 0xD928 to offset 0x4 sets bit 11 and opens the configuration registers, but only when update-permission is set. When update-permission is clear, the pair has no effect.
- R5: The unlocked state ends when a control write is accepted, or 128 cycles after it began, whichever comes first. Starting the unlocked state, and ending it on timeout, both clear bit 10.
- R6: Writing 0xA602 and then 0xB480 to offset 0x4 clears the counter. Counting restarts from 0 on the following cycle.
- R7: The second key word must arrive no more than 16 cycles after the first. Otherwise the pending sequence is dropped, and the late word is judged as a first word.
- R8: While enabled, any command word that is not a valid next key produces a reset request. This includes a first word of the other pair arriving in place of a second word. While disabled, such words are ignored.
- R9: With a nonzero window, a refresh that completes while the counter is below the window value produces a reset request instead of clearing the counter.
- R10: When the enabled counter equals the timeout limit, rst_req is high for exactly one cycle. After any reset request, the counter freezes and no further request is made until reset.
- R11: While enable is clear, the counter holds its value except when a refresh clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| rst_req | output | 1 | One-cycle reset request to the system reset logic |

## Verification
A key detector stuck in an armed state shows up on the next command write. That write either raises rst_req within two cycles or fails to clear the counter, which a counter read two cycles later exposes. A lock that is wrongly held open, or wrongly closed, shows at the ports only when software writes the timeout register and reads it back, so each lock test pairs a write with an immediate readback. A wrong staging delay in the control path is caught by reading the control word on each of the three cycles that follow the write. A counter that keeps running after a trip is caught by two counter reads taken some distance apart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_CMD  = 4;
  localparam int OFS_TOV  = 8;
  localparam int OFS_WIN  = 12;

  // control word bit positions (software polls these)
  localparam int BIT_UPD = 5;
  localparam int BIT_EN  = 7;
  localparam int BIT_RCS = 10;
  localparam int BIT_ULK = 11;

  // key words written to the command register
  localparam logic [31:0] KEY_REF_A = 32'h0000_A602;
  localparam logic [31:0] KEY_REF_B = 32'h0000_B480;
  localparam logic [31:0] KEY_ULK_A = 32'h0000_C520;
  localparam logic [31:0] KEY_ULK_B = 32'h0000_D928;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REF  = 2'd1,
    SQ_ULK  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/wdt_seq.sv
module wdt_seq
  import wdt_pkg::*;
#(
  parameter int GAP = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  output logic        refresh_ok,
  output logic        unlock_ok,
  output logic        bad_word
);
  localparam int GW = $clog2(GAP + 1);

  seq_st_e         st_q;
  logic [GW-1:0]   gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SQ_IDLE;
      gap_q      <= '0;
      refresh_ok <= 1'b0;
      unlock_ok  <= 1'b0;
      bad_word   <= 1'b0;
    end else begin
      refresh_ok <= 1'b0;
      unlock_ok  <= 1'b0;
      bad_word   <= 1'b0;
      if (cmd_wr) begin
        st_q  <= SQ_IDLE;
        gap_q <= '0;
        case (st_q)
          SQ_IDLE: begin
            if (cmd_word == KEY_REF_A)      st_q <= SQ_REF;
            else if (cmd_word == KEY_ULK_A) st_q <= SQ_ULK;
            else                            bad_word <= 1'b1;
          end
          SQ_REF: begin
            if (cmd_word == KEY_REF_B) refresh_ok <= 1'b1;
            else                       bad_word   <= 1'b1;
          end
          SQ_ULK: begin
            if (cmd_word == KEY_ULK_B) unlock_ok <= 1'b1;
            else                       bad_word  <= 1'b1;
          end
          default: bad_word <= 1'b1;
        endcase
      end else if (st_q != SQ_IDLE) begin
        if (gap_q == GW'(GAP - 1)) begin
          st_q  <= SQ_IDLE;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               ULK_WIN = 128,
  parameter int               RECFG   = 2,
  parameter logic [CNT_W-1:0] TOV_RST = 'h400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_tov,
  input  logic             wr_win,
  input  logic [31:0]      wdata,
  input  logic             unlock_ok,
  output logic             en,
  output logic             upd,
  output logic [CNT_W-1:0] tov,
  output logic [CNT_W-1:0] win,
  output logic             unlocked,
  output logic             rcs,
  output logic             cfg_apply,
  output logic             pending
);
  localparam int UW = $clog2(ULK_WIN);
  localparam int RW = $clog2(RECFG + 1);

  logic          first_done;
  logic [UW-1:0] ulk_cnt;
  logic [RW-1:0] pend_cnt;
  logic          pend_en;
  logic          pend_upd;
  logic          open_w;

  assign open_w  = unlocked | (~upd & ~first_done);
  assign pending = (pend_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b1;
      upd        <= 1'b0;
      tov        <= TOV_RST;
      win        <= '0;
      unlocked   <= 1'b0;
      rcs        <= 1'b0;
      cfg_apply  <= 1'b0;
      first_done <= 1'b0;
      ulk_cnt    <= '0;
      pend_cnt   <= '0;
      pend_en    <= 1'b0;
      pend_upd   <= 1'b0;
    end else begin
      cfg_apply <= 1'b0;
      if (open_w && wr_tov) tov <= wdata[CNT_W-1:0];
      if (open_w && wr_win) win <= wdata[CNT_W-1:0];

      // staged control word lands after RECFG cycles
      if (pend_cnt != '0) begin
        pend_cnt <= pend_cnt - 1'b1;
        if (pend_cnt == RW'(1)) begin
          en        <= pend_en;
          upd       <= pend_upd;
          rcs       <= 1'b1;
          cfg_apply <= 1'b1;
        end
      end

      if (open_w && wr_ctrl) begin
        pend_en    <= wdata[BIT_EN];
        pend_upd   <= wdata[BIT_UPD];
        pend_cnt   <= RW'(RECFG);
        unlocked   <= 1'b0;
        first_done <= 1'b1;
        rcs        <= 1'b0;
        ulk_cnt    <= '0;
      end else if (unlock_ok && upd && pend_cnt == '0) begin
        unlocked <= 1'b1;
        ulk_cnt  <= '0;
        rcs      <= 1'b0;
      end else if (unlocked) begin
        if (ulk_cnt == UW'(ULK_WIN - 1)) begin
          unlocked <= 1'b0;
          rcs      <= 1'b0;
          ulk_cnt  <= '0;
        end else begin
          ulk_cnt <= ulk_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] tov,
  input  logic [CNT_W-1:0] win,
  input  logic             refresh_ok,
  input  logic             bad_word,
  input  logic             cfg_apply,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req,
  output logic             tripped
);
  logic early_w;

  assign early_w = (win != '0) && (cnt < win);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
      tripped <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!tripped) begin
        if (bad_word && en) begin
          rst_req <= 1'b1;
          tripped <= 1'b1;
        end else if (refresh_ok) begin
          if (en && early_w) begin
            rst_req <= 1'b1;
            tripped <= 1'b1;
          end else begin
            cnt <= '0;
          end
        end else if (cfg_apply) begin
          cnt <= '0;
        end else if (en) begin
          if (cnt == tov) begin
            rst_req <= 1'b1;
            tripped <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdt_seqlock.sv
module wdt_seqlock
  import wdt_pkg::*;
#(
  parameter int               ADDR_W    = 4,
  parameter int               CNT_W     = 16,
  parameter int               GAP_CYC   = 16,
  parameter int               ULK_CYC   = 128,
  parameter int               RECFG_CYC = 2,
  parameter logic [CNT_W-1:0] TOV_RST   = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  logic sel_ctrl, sel_cmd, sel_tov, sel_win;
  logic refresh_ok, unlock_ok, bad_word;
  logic cfg_en, cfg_upd, cfg_ulk, cfg_rcs, cfg_apply, cfg_pend;
  logic [CNT_W-1:0] cfg_tov, cfg_win, cnt_val;
  logic cnt_trip;
  logic [31:0] ctrl_word;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign sel_tov  = (bus_addr == ADDR_W'(OFS_TOV));
  assign sel_win  = (bus_addr == ADDR_W'(OFS_WIN));

  wdt_seq #(.GAP(GAP_CYC)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (bus_wr & sel_cmd),
    .cmd_word  (bus_wdata),
    .refresh_ok(refresh_ok),
    .unlock_ok (unlock_ok),
    .bad_word  (bad_word)
  );

  wdt_cfg #(
    .CNT_W  (CNT_W),
    .ULK_WIN(ULK_CYC),
    .RECFG  (RECFG_CYC),
    .TOV_RST(TOV_RST)
  ) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (bus_wr & sel_ctrl),
    .wr_tov   (bus_wr & sel_tov),
    .wr_win   (bus_wr & sel_win),
    .wdata    (bus_wdata),
    .unlock_ok(unlock_ok),
    .en       (cfg_en),
    .upd      (cfg_upd),
    .tov      (cfg_tov),
    .win      (cfg_win),
    .unlocked (cfg_ulk),
    .rcs      (cfg_rcs),
    .cfg_apply(cfg_apply),
    .pending  (cfg_pend)
  );

  wdt_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en),
    .tov       (cfg_tov),
    .win       (cfg_win),
    .refresh_ok(refresh_ok),
    .bad_word  (bad_word),
    .cfg_apply (cfg_apply),
    .cnt       (cnt_val),
    .rst_req   (rst_req),
    .tripped   (cnt_trip)
  );

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[BIT_EN]  = cfg_en;
    ctrl_word[BIT_UPD] = cfg_upd;
    ctrl_word[BIT_RCS] = cfg_rcs;
    ctrl_word[BIT_ULK] = cfg_ulk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (sel_ctrl)     bus_rdata <= ctrl_word;
      else if (sel_cmd) bus_rdata <= 32'(cnt_val);
      else if (sel_tov) bus_rdata <= 32'(cfg_tov);
      else if (sel_win) bus_rdata <= 32'(cfg_win);
    end
  end
endmodule

// File: rtl/wdt_seqlock_chk.sv
module wdt_seqlock_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_req,
  input logic             tripped,
  input logic             en,
  input logic             upd,
  input logic             unlocked,
  input logic             rcs,
  input logic             pend,
  input logic             refresh_ok,
  input logic             unlock_ok,
  input logic             bad_word,
  input logic             cfg_apply,
  input logic [CNT_W-1:0] cnt
);
  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R10
  trip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tripped |=> !rst_req);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !refresh_ok && !cfg_apply) |=> $stable(cnt));

  // R4
  ulk_perm_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> upd);

  // R3
  rcs_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rcs) |-> $past(pend));

  // R6
  refresh_clear_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_ok |=> (cnt == '0 || tripped));

  // R8
  seq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({refresh_ok, unlock_ok, bad_word}));
endmodule

bind wdt_seqlock wdt_seqlock_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rst_req   (rst_req),
  .tripped   (cnt_trip),
  .en        (cfg_en),
  .upd       (cfg_upd),
  .unlocked  (cfg_ulk),
  .rcs       (cfg_rcs),
  .pend      (cfg_pend),
  .refresh_ok(refresh_ok),
  .unlock_ok (unlock_ok),
  .bad_word  (bad_word),
  .cfg_apply (cfg_apply),
  .cnt       (cnt_val)
);

// File: tb/wdt_seqlock_tb_top.sv
module wdt_seqlock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int nchk = 0;
  int nfail = 0;
  int pulses = 0;
  int wide = 0;
  logic prev_req = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_seqlock dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rst_req) begin
        pulses = pulses + 1;
        if (prev_req) wide = wide + 1;
      end
      prev_req = rst_req;
    end else begin
      prev_req = 1'b0;
    end
  end

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_ID = 2'd2;
  localparam int NV = 26;
  // {op, requirement, offset, data or expected value}
  localparam logic [41:0] VEC [NV] = '{
    {OP_RD, 4'd1, 4'h0, 32'h0000_0080},  // R1 control reset value
    {OP_RD, 4'd1, 4'h8, 32'h0000_0400},  // R1 timeout reset value
    {OP_RD, 4'd1, 4'hC, 32'h0000_0000},  // R1 window reset value
    {OP_WR, 4'd2, 4'hC, 32'h0000_0010},  // R2 first-time write
    {OP_WR, 4'd2, 4'h8, 32'h0000_0200},
    {OP_WR, 4'd2, 4'h0, 32'h0000_0120},
    {OP_ID, 4'd0, 4'h0, 32'd4},
    {OP_RD, 4'd3, 4'h0, 32'h0000_0420},  // R3 applied, complete flag
    {OP_RD, 4'd2, 4'h8, 32'h0000_0200},
    {OP_RD, 4'd2, 4'hC, 32'h0000_0010},
    {OP_WR, 4'd2, 4'h8, 32'h0000_0300},  // R2 now locked
    {OP_RD, 4'd2, 4'h8, 32'h0000_0200},
    {OP_WR, 4'd4, 4'h4, 32'h0000_C520},  // R4 unlock pair
    {OP_WR, 4'd4, 4'h4, 32'h0000_D928},
    {OP_ID, 4'd0, 4'h0, 32'd1},
    {OP_RD, 4'd4, 4'h0, 32'h0000_0820},
    {OP_WR, 4'd4, 4'h8, 32'h0000_0300},
    {OP_RD, 4'd4, 4'h8, 32'h0000_0300},
    {OP_WR, 4'd3, 4'h0, 32'h0000_00A0},
    {OP_ID, 4'd0, 4'h0, 32'd4},
    {OP_RD, 4'd3, 4'h0, 32'h0000_04A0},
    {OP_ID, 4'd0, 4'h0, 32'd30},
    {OP_WR, 4'd6, 4'h4, 32'h0000_A602},  // R6 refresh pair
    {OP_WR, 4'd6, 4'h4, 32'h0000_B480},
    {OP_ID, 4'd0, 4'h0, 32'd2},
    {OP_RD, 4'd6, 4'h4, 32'h0000_0001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int base;
    @(negedge clk);
    do_reset();
    check("R1 rst_req low after reset", {31'b0, rst_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      case (v[41:40])
        OP_WR: wr(v[35:32], v[31:0]);
        OP_ID: idle(int'(v[31:0]));
        default: begin
          rd(v[35:32], d);
          check($sformatf("R%0d table[%0d]", v[39:36], i), d, v[31:0]);
        end
      endcase
    end
    check("R9 no request during table", pulses, 0);

    // R3 staging delay, then R5 relock by timeout
    do_reset();
    wr(4'h0, 32'h20);
    rd(4'h0, d); check("R3 one cycle after write", d, 32'h80);
    rd(4'h0, d); check("R3 two cycles after write", d, 32'h80);
    rd(4'h0, d); check("R3 applied", d, 32'h420);
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    idle(140);
    rd(4'h0, d); check("R5 relocked, flags clear", d, 32'h20);
    wr(4'h8, 32'h77);
    rd(4'h8, d); check("R5 write ignored after relock", d, 32'h400);
    // R11 disabled counter holds; R8 bad word ignored while disabled
    base = pulses;
    rd(4'h4, d); idle(20); rd(4'h4, d2);
    check("R11 counter holds while disabled", d2, d);
    wr(4'h4, 32'h1234); idle(3);
    check("R8 bad word ignored while disabled", pulses - base, 0);

    // R4 unlock ignored without update permission
    do_reset();
    wr(4'h0, 32'h80); idle(4);
    rd(4'h0, d); check("R2 first control write applied", d, 32'h480);
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928); idle(2);
    rd(4'h0, d); check("R4 unlock ignored, no bit 11", d, 32'h480);
    wr(4'h8, 32'h55);
    rd(4'h8, d); check("R4 timeout stays locked", d, 32'h400);

    // R8 bad words while enabled
    do_reset(); base = pulses;
    wr(4'h4, 32'h1234); idle(3);
    check("R8 unknown word raises request", pulses - base, 1);
    do_reset(); base = pulses;
    wr(4'h4, 32'hA602); wr(4'h4, 32'hC520); idle(3);
    check("R8 out-of-order word raises request", pulses - base, 1);

    // R7 gap limit
    do_reset(); base = pulses;
    wr(4'h4, 32'hA602); idle(20); wr(4'h4, 32'hB480); idle(3);
    check("R7 late second word is a fault", pulses - base, 1);
    do_reset(); base = pulses;
    wr(4'h4, 32'hA602); idle(10); wr(4'h4, 32'hB480); idle(2);
    rd(4'h4, d); check("R7 timely refresh clears counter", d, 32'd1);
    check("R7 timely refresh no request", pulses - base, 0);

    // R9 early refresh inside window, then R10 freeze
    do_reset(); base = pulses;
    wr(4'hC, 32'h40); wr(4'h0, 32'hA0); idle(5);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480); idle(3);
    check("R9 early refresh raises request", pulses - base, 1);
    rd(4'h4, d); idle(10); rd(4'h4, d2);
    check("R10 counter frozen after trip", d2, d);

    // R10 timeout pulse
    do_reset(); base = pulses; wide = 0;
    wr(4'h8, 32'h20); wr(4'h0, 32'hA0); idle(60);
    check("R10 exactly one request", pulses - base, 1);
    check("R10 request lasts one cycle", wide, 0);
    rd(4'h4, d); check("R10 counter stops at limit", d, 32'h20);
    idle(20);
    check("R10 no further request", pulses - base, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule